// File: doc/BRIEF.md
# Deferred Routine Priority Scheduler

This block holds pending requests for deferred routines and feeds them, one at a time, to a single executor. Each request carries a class number and an 8-bit routine identifier. Requests of one class wait in their own first-in, first-out list. There are four such lists, ranked by fixed priority.

Only one routine is outstanding at any moment. When the executor is idle and work is waiting, the block picks the oldest entry of the highest-ranked non-empty list. It pulses a start strobe with that identifier and marks itself busy. Requests that arrive later, including ones of higher rank, wait until the executor reports that the routine has finished or has suspended itself. Only then does the block choose again. A list that is full rejects further requests and keeps a sticky overflow flag for that list.

Top module: `deferred_sched`

## Requirements
- R1: After reset, start_o, busy_o, full_o and ovf_o are all zero and every list is empty.
- R2: act_list_i selects the list: 0 holds hardware-failure and drum-completion routines, 1 holds tape routines, 2 holds other peripheral routines, and 3 holds program-initiated routines. A lower list number means higher priority.
- R3: Within one list, identifiers are started in the order in which they were accepted.
- R4: A selection always takes the head of the lowest-numbered non-empty list.
- R5: While busy_o is high, no start_o is issued, whatever activations arrive.
- R6: Each cycle in which the block is idle and some list holds an entry is a selection cycle. start_o is then high for exactly one cycle, starting the cycle after the selection cycle, and busy_o rises together with it.
- R7: A done_i or halt_i pulse while busy clears busy_o on the next cycle, and the cycle after that pulse is a selection cycle if work is waiting. done_i and halt_i have no effect while idle.
- R8: An activation presented in the same cycle as done_i or halt_i takes part in the selection that follows.
- R9: Each list holds 8 entries. full_o[n] is high when list n holds 8 entries. An activation into a full list that is not being popped in that cycle is dropped and sets ovf_o[n], which stays set until reset.
- R10: An activation into a full list in the same cycle that the list's head is selected is accepted. No entry is lost or duplicated.
- R11: start_id_o equals the identifier of the selected entry while start_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| act_valid_i | input | 1 | Activation request strobe |
| act_list_i | input | 2 | Target list of the activation, 0 highest |
| act_id_i | input | 8 | Routine identifier to queue |
| done_i | input | 1 | Running routine has concluded |
| halt_i | input | 1 | Running routine has suspended itself |
| start_o | output | 1 | One-cycle start strobe to the executor |
| start_id_o | output | 8 | Identifier of the routine being started |
| busy_o | output | 1 | A routine is outstanding |
| full_o | output | 4 | Per-list full flags |
| ovf_o | output | 4 | Per-list sticky overflow flags |

## Verification
A behavioural model holds one queue per list and is compared with the design on every cycle. Stimulus loads several lists while a routine is running, to check that later high-rank arrivals wait without preempting and then win the next selection. Runs of same-list activations ended by alternating done and halt pulses show FIFO order. Activations placed in the same cycle as the finishing pulse show whether they take part in the next selection. Overfilling a list and then refilling it during the cycle that pops its head tells a dropped entry apart from one accepted through the freed slot. Stray done pulses while idle show that nothing starts spuriously.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned SCHED_LISTS = 4;
  localparam int unsigned SCHED_DEPTH = 8;
  localparam int unsigned SCHED_ID_W  = 8;

  // list ranking, lower value wins
  typedef enum logic [1:0] {
    CLS_FAULT  = 2'd0,
    CLS_TAPE   = 2'd1,
    CLS_PERIPH = 2'd2,
    CLS_PROG   = 2'd3
  } sched_cls_e;
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned ID_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [ID_W-1:0] wr_data_i,
  input  logic            rd_i,
  output logic [ID_W-1:0] head_o,
  output logic            empty_o,
  output logic            full_o,
  output logic            ovf_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [ID_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]   wptr_q, rptr_q;
  logic [CW-1:0]   count_q;
  logic            ovf_q;
  logic            accept, do_rd;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign head_o  = mem_q[rptr_q];
  assign ovf_o   = ovf_q;

  // a pop in the same cycle frees the slot for the write
  assign do_rd  = rd_i && !empty_o;
  assign accept = wr_i && (!full_o || do_rd);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (accept) wptr_q <= nxt(wptr_q);
      if (do_rd)  rptr_q <= nxt(rptr_q);
      case ({accept, do_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
      if (wr_i && !accept) ovf_q <= 1'b1;
    end
  end

  p_drop_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && full_o && !rd_i |=> full_o && ovf_o && count_q == $past(count_q));

  p_push_pop_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && rd_i && full_o |=> full_o && $stable(ovf_o));

  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/sched_prio.sv
module sched_prio #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
  assign any_o = |req_i;

  always_comb begin
    p_grant_onehot_r4: assert ($onehot0(grant_o));
    p_grant_req_r4: assert ((grant_o & ~req_i) == '0);
  end
endmodule

// File: rtl/deferred_sched.sv
module deferred_sched #(
  parameter int unsigned NUM_LISTS = sched_pkg::SCHED_LISTS,
  parameter int unsigned DEPTH     = sched_pkg::SCHED_DEPTH,
  parameter int unsigned ID_W      = sched_pkg::SCHED_ID_W,
  localparam int unsigned LW       = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_valid_i,
  input  logic [LW-1:0]        act_list_i,
  input  logic [ID_W-1:0]      act_id_i,
  input  logic                 done_i,
  input  logic                 halt_i,
  output logic                 start_o,
  output logic [ID_W-1:0]      start_id_o,
  output logic                 busy_o,
  output logic [NUM_LISTS-1:0] full_o,
  output logic [NUM_LISTS-1:0] ovf_o
);
  logic [ID_W-1:0]      head_w [NUM_LISTS];
  logic [NUM_LISTS-1:0] nonempty, grant, rd;
  logic [LW-1:0]        sel_idx;
  logic                 any_req, sel;
  logic                 busy_q, start_q;
  logic [ID_W-1:0]      start_id_q;

  for (genvar g = 0; g < NUM_LISTS; g++) begin : g_list
    logic empty_w;
    sched_fifo #(.DEPTH(DEPTH), .ID_W(ID_W)) u_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (act_valid_i && act_list_i == LW'(g)),
      .wr_data_i (act_id_i),
      .rd_i      (rd[g]),
      .head_o    (head_w[g]),
      .empty_o   (empty_w),
      .full_o    (full_o[g]),
      .ovf_o     (ovf_o[g])
    );
    assign nonempty[g] = !empty_w;
    assign rd[g]       = sel && grant[g];
  end

  sched_prio #(.N(NUM_LISTS)) u_prio (
    .req_i   (nonempty),
    .grant_o (grant),
    .idx_o   (sel_idx),
    .any_o   (any_req)
  );

  // non-preemptive: choose only when nothing is outstanding
  assign sel = !busy_q && any_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
      start_id_q <= '0;
    end else begin
      start_q <= sel;
      if (sel) start_id_q <= head_w[sel_idx];
      if (busy_q && (done_i || halt_i)) busy_q <= 1'b0;
      else if (sel)                     busy_q <= 1'b1;
    end
  end

  assign start_o    = start_q;
  assign start_id_o = start_id_q;
  assign busy_o     = busy_q;

  p_start_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_start_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);

  p_no_preempt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i && !halt_i |=> busy_o && !start_o);

  p_finish_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (done_i || halt_i) |=> !busy_o);

  p_idle_waits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !any_req |=> !start_o && !busy_o);

  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o != '0 |=> (ovf_o & $past(ovf_o)) == $past(ovf_o));
endmodule

// File: tb/deferred_sched_bench.sv
module deferred_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_v = 1'b0;
  logic [1:0] act_l = '0;
  logic [7:0] act_id = '0;
  logic       done = 1'b0, halt = 1'b0;
  logic       start, busy;
  logic [7:0] start_id;
  logic [3:0] full, ovf;

  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  deferred_sched u_deferred_sched (
    .clk_i(clk), .rst_ni(rst_n), .act_valid_i(act_v), .act_list_i(act_l),
    .act_id_i(act_id), .done_i(done), .halt_i(halt), .start_o(start),
    .start_id_o(start_id), .busy_o(busy), .full_o(full), .ovf_o(ovf)
  );

  // behavioural reference
  int         q [4][$];
  bit         m_busy, m_start;
  bit [7:0]   m_id;
  bit [3:0]   m_ovf;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 4; l++) q[l].delete();
      m_busy = 0; m_start = 0; m_id = 0; m_ovf = 0;
    end else begin
      bit s; int sl;
      s = 0; sl = 0;
      if (!m_busy)
        for (int l = 3; l >= 0; l--) if (q[l].size() > 0) begin s = 1; sl = l; end
      m_start = s;
      if (s) m_id = 8'(q[sl].pop_front());
      if (act_v) begin
        if (q[act_l].size() < 8) q[act_l].push_back(int'(act_id));
        else m_ovf[act_l] = 1'b1;
      end
      if (m_busy && (done || halt)) m_busy = 0;
      else if (s) m_busy = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit [3:0] m_full;
      for (int l = 0; l < 4; l++) m_full[l] = (q[l].size() == 8);
      chk("R5 R6 start", int'(start), int'(m_start));
      if (m_start) chk("R3 R4 R11 start_id", int'(start_id), int'(m_id));
      chk("R7 R8 busy", int'(busy), int'(m_busy));
      chk("R9 R10 full", int'(full), int'(m_full));
      chk("R2 R9 ovf", int'(ovf), int'(m_ovf));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R6 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic cyc(input bit v, input int l, input int id, input bit d, input bit h);
    act_v = v; act_l = 2'(l); act_id = 8'(id); done = d; halt = h;
    @(negedge clk);
    act_v = 0; done = 0; halt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset values
    chk("R1 start", int'(start), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 ovf", int'(ovf), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R6 single activation, R7 stray done while idle
    cyc(1, 2, 8'h21, 0, 0);
    idle(3);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    idle(2);
    // R5 R4: queue low and high work while busy
    cyc(1, 3, 8'h30, 0, 0);
    idle(1);
    cyc(1, 3, 8'h31, 0, 0);
    cyc(1, 1, 8'h10, 0, 0);
    cyc(1, 0, 8'h01, 0, 0);
    cyc(1, 2, 8'h22, 0, 0);
    idle(3);
    for (int i = 0; i < 5; i++) begin cyc(0, 0, 0, i[0], !i[0]); idle(2); end
    // R3 FIFO order in one list with alternating halt and done
    for (int i = 0; i < 5; i++) cyc(1, 1, 8'h40 + i, 0, 0);
    for (int i = 0; i < 5; i++) begin idle(1); cyc(0, 0, 0, !i[0], i[0]); end
    idle(2);
    // R8 activation in the same cycle as done
    cyc(1, 3, 8'h50, 0, 0);
    idle(2);
    cyc(1, 3, 8'h51, 0, 0);
    cyc(1, 0, 8'h05, 1, 0);
    idle(2);
    cyc(0, 0, 0, 1, 0);
    idle(2);
    cyc(0, 0, 0, 0, 1);
    idle(3);
    // R9 overfill list 3 while busy
    cyc(1, 2, 8'h60, 0, 0);
    for (int i = 0; i < 10; i++) cyc(1, 3, 8'h70 + i, 0, 0);
    idle(2);
    // R10 refill full list 3 in its selection cycle
    cyc(0, 0, 0, 1, 0);
    cyc(1, 3, 8'h99, 0, 0);
    idle(2);
    cyc(1, 3, 8'h9a, 0, 0);
    // drain
    for (int i = 0; i < 12; i++) begin idle(1); cyc(0, 0, 0, 1, 0); end
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule